// File: doc/BRIEF.md
# Run-time Programmable Second-Order Recursive Filter Section

This block is one second-order recursive filter section: three feed-forward taps and two feedback taps over a stream of two's-complement samples. A sample is taken on every clock cycle on which the sample-valid input is high. The filtered result appears one cycle later with its own valid flag. Both the sample width and the coefficient width are parameters. The coefficient width may be at most 16 bits. Coefficients are fixed point with a parameterised number of fraction bits. By default there are two integer bits, so a coefficient spans roughly -2 to just under +2.

A host programs the five coefficients through a Wishbone slave port and can read them back. The filter response can therefore be changed while the section runs. The output sample has the same width and format as the input, so sections can be chained to build higher orders. Both feedback products are added. A host that wants the usual subtractive form must store the feedback coefficients already negated.

Top module: `biquad_section`

## Requirements
- R1: On each accepted sample the output is floor((c0·x[n] + c1·x[n-1] + c2·x[n-2] + c3·y[n-1] + c4·y[n-2]) / 2^FRAC). The sum is taken at full precision, both feedback terms carry a plus sign, and FRAC defaults to coefficient width minus 2.
- R2: If the shifted sum lies outside the signed output range, the output is clamped to the largest or the smallest representable value. It never wraps.
- R3: The output valid is high exactly one cycle after a cycle with input valid high. The output sample changes only on that cycle and holds its value otherwise.
- R4: The input and output history advance only on accepted samples. Idle cycles between samples, of any number, leave the filter result unchanged.
- R5: Word addresses 0 to 4 hold c0 (current-input tap), c1, c2, c3 (first feedback tap) and c4. Each is written and read back through the Wishbone port with its full coefficient width, on data bits [CW-1:0].
- R6: A read of addresses 5 to 7 returns zero. A write to those addresses changes no coefficient.
- R7: Each strobed Wishbone cycle (cyc and stb high) receives ack on the following clock edge, for exactly one cycle. A write takes effect on the strobe edge. Read data is valid while ack is high.
- R8: Synchronous reset clears the history, the output sample and both valid/ack flags. It sets c0 to 1.0 (2^FRAC) and all other coefficients to zero, so the section passes its input straight through.
- R9: The arithmetic uses a working copy of the coefficients. That copy is loaded from the bus registers on each accepted sample, after that sample has been computed. A coefficient written while idle is therefore first used by the second sample accepted after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Bus write enable |
| wb_adr_i | input | 3 | Coefficient word address |
| wb_dat_i | input | CW | Bus write data |
| wb_dat_o | output | CW | Bus read data |
| wb_ack_o | output | 1 | Bus acknowledge |
| smp_valid_i | input | 1 | Input sample valid |
| smp_i | input | DW | Input sample, two's complement |
| smp_valid_o | output | 1 | Output sample valid |
| smp_o | output | DW | Filtered sample, two's complement |

## Verification
Each sample result is due one clock edge after the edge that accepts it. The bench drives inputs on the falling edge and checks the output at the next falling edge, half a cycle after the register has loaded. For back-to-back samples it checks each result at the same falling edge on which it drives the next sample. Bus ack and read data are due on the edge after the strobe edge and are checked at the following falling edge. One more falling edge then confirms that ack has dropped. The reference model keeps its own bus and working coefficient sets, so the one-sample lag in R9 appears in the expected values rather than being hidden by extra idle samples.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  localparam int NUM_COEF = 5;
  localparam int ADR_W    = 3;

  // Coefficient word addresses; the order is the bus map.
  typedef enum logic [ADR_W-1:0] {
    K_FF0 = 3'd0,
    K_FF1 = 3'd1,
    K_FF2 = 3'd2,
    K_FB1 = 3'd3,
    K_FB2 = 3'd4
  } coef_idx_e;
endpackage

// File: rtl/bq_coef_bank.sv
module bq_coef_bank
  import biquad_pkg::*;
#(
  parameter int CW   = 16,
  parameter int FRAC = CW - 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wb_cyc_i,
  input  logic                 wb_stb_i,
  input  logic                 wb_we_i,
  input  logic [ADR_W-1:0]     wb_adr_i,
  input  logic [CW-1:0]        wb_dat_i,
  output logic [CW-1:0]        wb_dat_o,
  output logic                 wb_ack_o,
  input  logic                 smp_take,
  output logic signed [CW-1:0] work_o [NUM_COEF]
);
  localparam logic signed [CW-1:0] UNITY = CW'(1) << FRAC;

  logic signed [CW-1:0] host_q [NUM_COEF];
  logic                 bus_hit;
  logic                 wr_fire;
  logic [CW-1:0]        rd_mux;

  assign bus_hit = wb_cyc_i && wb_stb_i && !wb_ack_o;
  assign wr_fire = bus_hit && wb_we_i;

  for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef
    localparam logic signed [CW-1:0] RST_V = (i == int'(K_FF0)) ? UNITY : '0;
    always_ff @(posedge clk) begin
      if (rst) begin
        host_q[i] <= RST_V;
        work_o[i] <= RST_V;
      end else begin
        if (wr_fire && wb_adr_i == ADR_W'(i)) host_q[i] <= wb_dat_i;
        if (smp_take) work_o[i] <= host_q[i];
      end
    end

    // R9
    work_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !smp_take |=> $stable(work_o[i]));
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_COEF; i++)
      if (wb_adr_i == ADR_W'(i)) rd_mux = host_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_ack_o <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      wb_ack_o <= bus_hit;
      if (bus_hit) wb_dat_o <= rd_mux;
    end
  end

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |=> !wb_ack_o);
  // R7
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));
  // R6
  unused_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_ack_o && !$past(wb_we_i) && $past(wb_adr_i) >= ADR_W'(NUM_COEF))
      |-> wb_dat_o == '0);
endmodule

// File: rtl/bq_datapath.sv
module bq_datapath
  import biquad_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = CW - 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid_i,
  input  logic signed [DW-1:0] smp_i,
  input  logic signed [CW-1:0] coef_i [NUM_COEF],
  output logic                 smp_valid_o,
  output logic signed [DW-1:0] smp_o
);
  localparam int AW = DW + CW + 3;
  localparam logic signed [AW-1:0] Y_MAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] Y_MIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  function automatic logic signed [AW-1:0] tap(input logic signed [DW-1:0] s,
                                               input logic signed [CW-1:0] c);
    logic signed [AW-1:0] se, ce;
    se = {{(AW-DW){s[DW-1]}}, s};
    ce = {{(AW-CW){c[CW-1]}}, c};
    return se * ce;
  endfunction

  function automatic logic signed [AW-1:0] scale(input logic signed [AW-1:0] acc);
    return acc >>> FRAC;
  endfunction

  logic signed [DW-1:0] x1_q, x2_q, y2_q;
  logic signed [AW-1:0] acc, scaled;
  logic signed [DW-1:0] y_next;
  logic                 sat_hi, sat_lo;

  assign acc = tap(smp_i, coef_i[K_FF0]) + tap(x1_q, coef_i[K_FF1])
             + tap(x2_q, coef_i[K_FF2]) + tap(smp_o, coef_i[K_FB1])
             + tap(y2_q, coef_i[K_FB2]);
  assign scaled = scale(acc);
  assign sat_hi = scaled > Y_MAX;
  assign sat_lo = scaled < Y_MIN;

  always_comb begin
    if (sat_hi)      y_next = Y_MAX[DW-1:0];
    else if (sat_lo) y_next = Y_MIN[DW-1:0];
    else             y_next = scaled[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x1_q <= '0; x2_q <= '0; y2_q <= '0;
      smp_o <= '0; smp_valid_o <= 1'b0;
    end else begin
      smp_valid_o <= smp_valid_i;
      if (smp_valid_i) begin
        x1_q  <= smp_i;
        x2_q  <= x1_q;
        y2_q  <= smp_o;
        smp_o <= y_next;
      end
    end
  end

  // R3
  vld_lag_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid_i |=> smp_valid_o);
  // R3
  vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_valid_i |=> (!smp_valid_o && $stable(smp_o)));
  // R4
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_valid_i |=> ($stable(x1_q) && $stable(x2_q) && $stable(y2_q)));
  // R2
  clamp_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid_i && sat_hi) |=> smp_o == Y_MAX[DW-1:0]);
  // R2
  clamp_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid_i && sat_lo) |=> smp_o == Y_MIN[DW-1:0]);
endmodule

// File: rtl/biquad_section.sv
module biquad_section
  import biquad_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = CW - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wb_cyc_i,
  input  logic          wb_stb_i,
  input  logic          wb_we_i,
  input  logic [2:0]    wb_adr_i,
  input  logic [CW-1:0] wb_dat_i,
  output logic [CW-1:0] wb_dat_o,
  output logic          wb_ack_o,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_i,
  output logic          smp_valid_o,
  output logic [DW-1:0] smp_o
);
  logic signed [CW-1:0] work_coef [NUM_COEF];
  logic signed [DW-1:0] y_s;

  bq_coef_bank #(.CW(CW), .FRAC(FRAC)) u_coef (
    .clk(clk), .rst(rst),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
    .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
    .smp_take(smp_valid_i), .work_o(work_coef)
  );

  bq_datapath #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_dp (
    .clk(clk), .rst(rst),
    .smp_valid_i(smp_valid_i), .smp_i($signed(smp_i)),
    .coef_i(work_coef),
    .smp_valid_o(smp_valid_o), .smp_o(y_s)
  );

  assign smp_o = y_s;
endmodule

// File: tb/biquad_section_bench.sv
`timescale 1ns/1ps
module biquad_section_bench;
  localparam int DW = 16, CW = 16, FRAC = CW - 2;
  localparam longint YMAX = (64'sd1 <<< (DW-1)) - 1;
  localparam longint YMIN = -(64'sd1 <<< (DW-1));
  localparam longint ONE  = 64'sd1 <<< FRAC;

  logic clk = 0, rst = 1;
  logic wb_cyc_i = 0, wb_stb_i = 0, wb_we_i = 0;
  logic [2:0] wb_adr_i = '0;
  logic [CW-1:0] wb_dat_i = '0, wb_dat_o;
  logic wb_ack_o;
  logic smp_valid_i = 0;
  logic [DW-1:0] smp_i = '0, smp_o;
  logic smp_valid_o;

  int n_cmp = 0, n_bad = 0;
  longint m_host [5], m_work [5];
  longint mx1, mx2, my1, my2;

  always #10 clk = ~clk;

  biquad_section #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_biquad_section (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint ref_out(input longint x);
    longint acc, s;
    acc = m_work[0]*x + m_work[1]*mx1 + m_work[2]*mx2 + m_work[3]*my1 + m_work[4]*my2;
    s = acc >>> FRAC;
    if (s > YMAX) return YMAX;
    if (s < YMIN) return YMIN;
    return s;
  endfunction

  function automatic longint sx(input logic [CW-1:0] v);
    return longint'($signed(v));
  endfunction

  // All tasks start and end on a falling edge.
  task automatic bus_wr(input int adr, input longint val);
    smp_valid_i = 0;
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 1;
    wb_adr_i = 3'(adr); wb_dat_i = CW'(val);
    @(negedge clk);
    chk("R7 write ack", wb_ack_o, 1);
    wb_cyc_i = 0; wb_stb_i = 0; wb_we_i = 0;
    @(negedge clk);
    chk("R7 ack single cycle", wb_ack_o, 0);
    if (adr < 5) m_host[adr] = sx(CW'(val));
  endtask

  task automatic bus_rd(input int adr, input longint exp, input string tag);
    smp_valid_i = 0;
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 0; wb_adr_i = 3'(adr);
    @(negedge clk);
    chk("R7 read ack", wb_ack_o, 1);
    chk(tag, sx(wb_dat_o), exp);
    wb_cyc_i = 0; wb_stb_i = 0;
    @(negedge clk);
  endtask

  task automatic push(input longint x, input string tag);
    longint y;
    y = ref_out(x);
    smp_valid_i = 1; smp_i = DW'(x);
    @(negedge clk);
    chk("R3 valid lag", smp_valid_o, 1);
    chk(tag, longint'($signed(smp_o)), y);
    mx2 = mx1; mx1 = x; my2 = my1; my1 = y;
    for (int i = 0; i < 5; i++) m_work[i] = m_host[i];
  endtask

  task automatic idle(input int n);
    smp_valid_i = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R3 valid low when idle", smp_valid_o, 0);
      chk("R3 R4 output held", longint'($signed(smp_o)), my1);
    end
  endtask

  task automatic load_all(input longint c0, c1, c2, c3, c4);
    bus_wr(0, c0); bus_wr(1, c1); bus_wr(2, c2); bus_wr(3, c3); bus_wr(4, c4);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 5; i++) begin m_host[i] = 0; m_work[i] = 0; end
    m_host[0] = ONE; m_work[0] = ONE;
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8 reset state
    chk("R8 output zero", longint'($signed(smp_o)), 0);
    chk("R8 valid low", smp_valid_o, 0);
    chk("R8 ack low", wb_ack_o, 0);
    bus_rd(0, ONE, "R8 R5 c0 unity");
    for (int a = 1; a < 5; a++) bus_rd(a, 0, "R8 R5 coef zero");
    push(1234, "R8 passthrough");
    push(-32768, "R8 passthrough min");
    idle(2);

    // R5 / R6 map
    load_all(100, -200, 300, -400, 500);
    for (int a = 0; a < 5; a++) bus_rd(a, m_host[a], "R5 readback");
    bus_wr(6, 16'h7abc);
    bus_rd(6, 0, "R6 unused reads zero");
    bus_rd(5, 0, "R6 unused reads zero");
    for (int a = 0; a < 5; a++) bus_rd(a, m_host[a], "R6 write ignored");

    // R9 timing of new coefficients
    load_all(ONE, 0, 0, 0, 0);
    push(0, "R9 prime");
    push(0, "R9 prime");
    bus_wr(0, 2 * 8192 + 8192);   // 1.5
    push(1000, "R9 old set used");
    push(1000, "R9 new set used");

    // R1 feedback sign: y = x + 0.5*y[n-1]
    load_all(ONE, 0, 0, 8192, 0);
    push(0, "R1 prime"); push(0, "R1 prime");
    push(4000, "R1 feedback plus");
    idle(3);
    push(0, "R1 R4 after gap");
    push(0, "R1 decay");

    // R2 clamps
    load_all(32767, 0, 0, 0, 0);
    push(0, "R2 prime");
    push(30000, "R2 clamp high");
    push(-30000, "R2 clamp low");
    push(-1, "R1 floor of negative");

    // random, constrained
    for (int r = 0; r < 6; r++) begin
      longint c [5];
      for (int i = 0; i < 5; i++)
        c[i] = (r % 2 == 0) ? longint'($urandom_range(16384)) - 8192
                            : sx(CW'($urandom()));
      load_all(c[0], c[1], c[2], c[3], c[4]);
      for (int k = 0; k < 30; k++) begin
        push(sx(DW'($urandom())), "R1 R2 random");
        if ($urandom_range(3) != 0) idle(int'($urandom_range(3)));
      end
      idle(1);
    end

    // R8 synchronous reset mid-stream
    rst = 1; @(negedge clk); rst = 0;
    for (int i = 0; i < 5; i++) begin m_host[i] = 0; m_work[i] = 0; end
    m_host[0] = ONE; m_work[0] = ONE;
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    chk("R8 output cleared", longint'($signed(smp_o)), 0);
    push(-777, "R8 passthrough after reset");
    idle(1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule